// File: doc/BRIEF.md
# Johnson Decade Counter with Decoded Outputs

This block divides a count stream by ten and reports which of the ten counts is current on ten one-hot lines. It also drives a carry line for chaining several stages. The count is held in a five-bit twisted-ring shift register, so each step changes exactly one state bit. Each decoded line is formed from a pair of neighbouring register bits.

Two slow control levels, `cnt_clk_i` and `inhibit_i`, are sampled in the fast `clk_i` domain. Their edges are recovered by comparing successive samples. The count moves forward when `cnt_clk_i` rises while `inhibit_i` is low. It also moves forward when `inhibit_i` falls while `cnt_clk_i` is high, so the two inputs can swap roles. A separate active-high `clear_i` forces count zero at once, and its release is retimed to `clk_i`. Any register pattern outside the ten legal ones is pulled back to count zero by the next count event.

Top module: `decade_johnson_counter`

## Requirements
- R1: While `rst_ni` is low, `dec_o` reads 10'b0000000001 (count 0) and `carry_o` is 1.
- R2: In every legal state exactly one bit of `dec_o` is high. Bit i is high at count i.
- R3: A rising edge on `cnt_clk_i` while `inhibit_i` is low advances the count by one. Count 9 wraps to count 0.
- R4: A falling edge on `inhibit_i` while `cnt_clk_i` is high advances the count by one.
- R5: The count does not change on a falling `cnt_clk_i`, on a rising `inhibit_i`, on a rising `cnt_clk_i` while `inhibit_i` is high, on a falling `inhibit_i` while `cnt_clk_i` is low, or while both inputs are steady.
- R6: A high level on `clear_i` forces count 0 without waiting for `clk_i`, and it overrides every other input. A pulse shorter than one `clk_i` period still takes effect. Edges seen while the clear is active or being released do not count. Counting resumes after release.
- R7: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9, so it rises when the count wraps from 9 to 0.
- R8: If the state register holds a pattern that is not one of the ten legal codes, the next count event loads count 0.
- R9: An input edge applied between `clk_i` edges is visible on `dec_o` after the third following rising `clk_i` edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | Count clock level, sampled |
| inhibit_i | input | 1 | Active-high count inhibit, sampled; its falling edge counts while cnt_clk_i is high |
| clear_i | input | 1 | Asynchronous active-high clear to count 0 |
| dec_o | output | 10 | One-hot decoded count |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
A corrupted state register shows up on `dec_o` in the same cycle, because the decode is combinational. An illegal pattern drives several decoded lines high at once. A legal but wrong code moves the one-hot bit away from the position the modulo-10 model expects. The bench tracks that model through every edge combination of the two count inputs. It compares both the position and the carry after each step, so an off-by-one shows at the next sample. A forced illegal pattern checks that one count event is enough to get back to count 0.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int DEF_STAGES = 5;
  localparam int DEF_SYNC   = 2;

  // legal twisted-ring codes have at most one boundary between ones and zeros
  function automatic logic ring_legal(input logic [DEF_STAGES-1:0] q);
    return $countones(q[DEF_STAGES-1:1] ^ q[DEF_STAGES-2:0]) <= 1;
  endfunction
endpackage

// File: rtl/dc_sync_edge.sv
module dc_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/dc_clear_sync.sv
module dc_clear_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic hold_o
);
  logic [SYNC_STAGES-1:0] hold_q;

  // asserted asynchronously, released after SYNC_STAGES clean clocks
  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)      hold_q <= '1;
    else if (clear_i) hold_q <= '1;
    else              hold_q <= {hold_q[SYNC_STAGES-2:0], 1'b0};
  end

  assign hold_o = hold_q[SYNC_STAGES-1];
endmodule

// File: rtl/dc_johnson_core.sv
module dc_johnson_core
  import decade_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              hold_i,
  input  logic              step_i,
  output logic [STAGES-1:0] state_o,
  output logic              legal_o
);
  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;

  assign legal_o = $countones(state_q[STAGES-1:1] ^ state_q[STAGES-2:0]) <= 1;
  assign state_d = legal_o ? {state_q[STAGES-2:0], ~state_q[STAGES-1]} : '0;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)                state_q <= '0;
    else if (clear_i)           state_q <= '0;
    else if (hold_i)            state_q <= '0;
    else if (step_i)            state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dc_decoder.sv
module dc_decoder #(
  parameter int STAGES = 5,
  localparam int COUNT = 2 * STAGES
) (
  input  logic [STAGES-1:0] state_i,
  output logic [COUNT-1:0]  dec_o,
  output logic              carry_o
);
  assign dec_o[0]      = ~state_i[0] & ~state_i[STAGES-1];
  assign dec_o[STAGES] =  state_i[0] &  state_i[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_pair
    assign dec_o[k]          =  state_i[k-1] & ~state_i[k];
    assign dec_o[STAGES + k] = ~state_i[k-1] &  state_i[k];
  end

  assign carry_o = ~state_i[STAGES-1];
endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter
  import decade_pkg::*;
#(
  parameter int STAGES      = DEF_STAGES,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int COUNT      = 2 * STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             clear_i,
  output logic [COUNT-1:0] dec_o,
  output logic             carry_o
);
  logic cp_lvl, cp_rise, cp_fall;
  logic in_lvl, in_rise, in_fall;
  logic clr_hold, step, legal;
  logic [STAGES-1:0] state;

  dc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cp_sync (
    .clk_i, .rst_ni, .d_i(cnt_clk_i),
    .lvl_o(cp_lvl), .rise_o(cp_rise), .fall_o(cp_fall)
  );

  dc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i, .rst_ni, .d_i(inhibit_i),
    .lvl_o(in_lvl), .rise_o(in_rise), .fall_o(in_fall)
  );

  dc_clear_sync #(.SYNC_STAGES(SYNC_STAGES)) u_clr (
    .clk_i, .rst_ni, .clear_i, .hold_o(clr_hold)
  );

  // either input may act as the clock while the other gates it
  assign step = (cp_rise & ~in_lvl) | (in_fall & cp_lvl);

  dc_johnson_core #(.STAGES(STAGES)) u_core (
    .clk_i, .rst_ni, .clear_i, .hold_i(clr_hold), .step_i(step),
    .state_o(state), .legal_o(legal)
  );

  dc_decoder #(.STAGES(STAGES)) u_dec (
    .state_i(state), .dec_o, .carry_o
  );

  logic unused_edges;
  assign unused_edges = cp_fall ^ in_rise;
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int STAGES = 5,
  localparam int COUNT = 2 * STAGES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic [COUNT-1:0] dec_o,
  input logic             carry_o,
  input logic             step_i,
  input logic             legal_i,
  input logic             hold_i
);
  localparam logic [COUNT-1:0] ZERO_HOT = {{(COUNT-1){1'b0}}, 1'b1};

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> dec_o == ZERO_HOT && carry_o); // R1

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_i |-> $countones(dec_o) == 1); // R2

  AST_STEP_ROTATES: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    step_i && legal_i && !hold_i |=>
      (dec_o == {$past(dec_o[COUNT-2:0]), $past(dec_o[COUNT-1])}) || hold_i); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    !step_i && legal_i |=> $stable(dec_o) || hold_i || !legal_i); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> dec_o == ZERO_HOT); // R6

  AST_CARRY_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_i |-> carry_o == (|dec_o[STAGES-1:0])); // R7

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    step_i && !legal_i && !hold_i |=> dec_o == ZERO_HOT || hold_i); // R8
endmodule

bind decade_johnson_counter dc_checker #(.STAGES(STAGES)) u_chk (
  .clk_i, .rst_ni, .clear_i, .dec_o, .carry_o,
  .step_i(step), .legal_i(legal), .hold_i(clr_hold)
);

// File: tb/decade_johnson_counter_tb.sv
module decade_johnson_counter_tb;
  localparam int NV = 24;
  // {cnt_clk, inhibit, expected count}
  localparam logic [5:0] VEC [NV] = '{
    6'b10_0001, 6'b00_0001, 6'b10_0010, 6'b00_0010,
    6'b01_0010, 6'b11_0010, 6'b10_0011, 6'b11_0011,
    6'b10_0100, 6'b00_0100, 6'b10_0101, 6'b00_0101,
    6'b10_0110, 6'b00_0110, 6'b10_0111, 6'b11_0111,
    6'b10_1000, 6'b00_1000, 6'b10_1001, 6'b00_1001,
    6'b10_0000, 6'b00_0000, 6'b01_0000, 6'b00_0000
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cnt_clk = 1'b0, inhibit = 1'b0, clear = 1'b0;
  logic [9:0] dec;
  logic       carry;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  decade_johnson_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
    .clear_i(clear), .dec_o(dec), .carry_o(carry)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_count(input string req, input int c);
    chk(req, dec, 32'(1) << c);
    chk("R7", carry, c < 5);
    chk("R2", $countones(dec), 1);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic prev_cp;
    int   prev_c;
    string req;
    repeat (3) @(negedge clk);
    check_count("R1", 0);
    rst_ni = 1'b1;
    settle();
    check_count("R1", 0);

    prev_cp = 1'b0;
    prev_c  = 0;
    for (int i = 0; i < NV; i++) begin
      cnt_clk = VEC[i][5];
      inhibit = VEC[i][4];
      settle();
      if (int'(VEC[i][3:0]) == prev_c) req = "R5";
      else if (VEC[i][5] != prev_cp)   req = "R3";
      else                             req = "R4";
      check_count(req, int'(VEC[i][3:0]));
      prev_cp = VEC[i][5];
      prev_c  = int'(VEC[i][3:0]);
    end

    // R9: latency of exactly three clk edges
    cnt_clk = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_count("R9", 0);
    @(posedge clk);
    @(negedge clk);
    check_count("R9", 1);
    cnt_clk = 1'b0;
    settle();
    cnt_clk = 1'b1; settle();
    cnt_clk = 1'b0; settle();
    check_count("R3", 2);

    // R6: clear acts without a clock edge
    clear = 1'b1;
    #1;
    check_count("R6", 0);
    cnt_clk = 1'b1;
    settle();
    check_count("R6", 0);
    cnt_clk = 1'b0;
    clear = 1'b0;
    settle();
    check_count("R6", 0);
    cnt_clk = 1'b1; settle();
    check_count("R6", 1);
    cnt_clk = 1'b0; settle();
    // short pulse between edges
    #1 clear = 1'b1;
    #2 clear = 1'b0;
    settle();
    check_count("R6", 0);

    // R8: illegal pattern recovers on the next event
    force u_dut.u_core.state_q = 5'b01010;
    #1 release u_dut.u_core.state_q;
    @(negedge clk);
    cnt_clk = 1'b1; settle();
    check_count("R8", 0);
    cnt_clk = 1'b0; settle();
    cnt_clk = 1'b1; settle();
    check_count("R8", 1);

    // R1: reset mid-count
    rst_ni = 1'b0;
    #1;
    check_count("R1", 0);
    cnt_clk = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    settle();
    check_count("R1", 0);

    done = 1'b1;
    summary();
  end
endmodule